// File: doc/BRIEF.md
# Iterative BLAKE3 Compression Engine

This block performs the BLAKE3 compression function on one 64-byte message block. The caller presents a 256-bit chaining value, sixteen 32-bit message words, a 64-bit block counter, a 32-bit block length and a 32-bit flags word, then pulses `start`. The engine builds a sixteen-word working state and applies seven rounds of the quarter-round mix, computing `LANES` quarter-rounds in each clock cycle. It then presents a 512-bit result whose lower eight words are the folded state.

The caller waits for `done`. The result stays on `res_out` until the next accepted `start`. A `start` that arrives while the engine is busy is dropped, so a caller that is too eager cannot corrupt a compression in progress. `LANES` may be 1, 2 or 4. A run takes 56/`LANES` busy cycles.

Top module: `blk3_compress_core`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `res_out` is all zeros.
- R2: A `start` sampled while `busy` is 0 is accepted. In the next cycle `busy` is 1 and `done` is 0, including when `done` was 1 before.
- R3: A `start` sampled while `busy` is 1 is ignored. The run in progress keeps its inputs and its timing, and its result is unchanged.
- R4: `busy` stays high for exactly 56/`LANES` cycles. `done` rises in the cycle after the last busy cycle and stays high until the next accepted `start`.
- R5: While `done` is 1 and no `start` is given, `res_out` is stable, whatever the other inputs do.
- R6: The initial state is built as follows:
  - words 0..7 are the chaining value, where word i is `cv_in[32i+31:32i]`;
  - words 8..11 are 0x6A09E667, 0xBB67AE85, 0x3C6EF372, 0xA54FF53A;
  - word 12 is `ctr_in[31:0]` and word 13 is `ctr_in[63:32]`;
  - word 14 is `len_in` and word 15 is `flags_in`.
- R7: The quarter-round mix on (a,b,c,d) with message words x,y runs these steps in order. All additions are modulo 2^32.
  - a+=x+b, then d=(d^a) rotated right 16;
  - c+=d, then b=(b^c) rotated right 12;
  - a+=y+b, then d=(d^a) rotated right 8;
  - c+=d, then b=(b^c) rotated right 7.
- R8: Each round mixes four columns and then four diagonals.
  - Column g uses words (g, g+4, g+8, g+12).
  - Diagonal j uses words (j, 4+(j+1)%4, 8+(j+2)%4, 12+(j+3)%4).
  - Mix k of the round (columns k=0..3, diagonals k=4..7) takes schedule positions 2k and 2k+1.
- R9: The schedule of round 0 is the identity. The schedule of round r+1 at position i equals the schedule of round r at position P[i], where P = 2,6,3,10,7,0,4,13,1,11,12,5,9,14,15,8.
- R10: For i = 0..7, result word i is state word i XOR state word i+8 after the seventh round. Result words 8..15 are the final state words 8..15. Word i of the result is `res_out[32i+31:32i]`.
- R11: With the chaining value equal to the eight standard initial words, an all-zero message, counter 0, length 0 and flags 11, result words 0..7 are the standard BLAKE3 digest of the empty input.
- R12: `busy` and `done` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a compression; accepted only when idle |
| cv_in | input | 256 | Chaining value, word i at bits 32i+31:32i |
| msg_in | input | 512 | Sixteen message words, word i at bits 32i+31:32i |
| ctr_in | input | 64 | Block counter |
| len_in | input | 32 | Block length |
| flags_in | input | 32 | Domain flags |
| busy | output | 1 | Compression in progress |
| done | output | 1 | Result valid and held |
| res_out | output | 512 | Sixteen result words, word i at bits 32i+31:32i |

## Verification
The assertions assume that `start` is a plain level sampled on each clock edge. They also assume that the data inputs matter only in the cycle where `start` is accepted, so that stray `start` pulses or changing data during a run or during the hold period must be tolerated. The stimulus stays within these assumptions. It changes data only at the falling edge, and it deliberately raises `start` in the middle of a run and toggles data while `done` holds. Random chaining values, counters with non-zero upper halves, lengths and flags are checked against an independent model. The empty-input digest anchors that model to known values.

// File: rtl/blk3_pkg.sv
// Package: constants and helpers shared by the compression engine.
// Assumes 32-bit words and a sixteen-word state.
package blk3_pkg;
    localparam int WORDS  = 16;
    localparam int ROUNDS = 7;
    localparam int MIXES  = 8;   // quarter-round mixes per round

    typedef logic [31:0] word_t;
    typedef logic [3:0]  widx_t;

    typedef struct packed {
        widx_t a;
        widx_t b;
        widx_t c;
        widx_t d;
    } quad_t;

    localparam word_t IV [4] = '{32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A};

    // Message word reordering applied between rounds.
    localparam widx_t PERM [16] = '{4'd2, 4'd6, 4'd3, 4'd10, 4'd7, 4'd0, 4'd4, 4'd13,
                                    4'd1, 4'd11, 4'd12, 4'd5, 4'd9, 4'd14, 4'd15, 4'd8};

    // Map mix number k (0..3 columns, 4..7 diagonals) to its four state words.
    function automatic quad_t quad_of(input logic [2:0] k);
        quad_t q;
        logic [1:0] j;
        j = k[1:0];
        if (!k[2]) begin
            q.a = {2'b00, j};
            q.b = {2'b01, j};
            q.c = {2'b10, j};
            q.d = {2'b11, j};
        end else begin
            q.a = {2'b00, j};
            q.b = {2'b01, 2'(j + 2'd1)};
            q.c = {2'b10, 2'(j + 2'd2)};
            q.d = {2'b11, 2'(j + 2'd3)};
        end
        return q;
    endfunction
endpackage

// File: rtl/blk3_mix.sv
// Module: one quarter-round mix, purely combinational.
// Assumes the caller supplies the two message words for this mix position.
module blk3_mix
    import blk3_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    input  word_t x_i,
    input  word_t y_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);
    word_t a1, d1, c1, b1, a2, d2, c2, b2, t0, t1, t2, t3;

    // Eight dependent steps of the mix, in order.
    always_comb begin
        a1 = a_i + x_i + b_i;
        t0 = d_i ^ a1;
        d1 = {t0[15:0], t0[31:16]};
        c1 = c_i + d1;
        t1 = b_i ^ c1;
        b1 = {t1[11:0], t1[31:12]};
        a2 = a1 + y_i + b1;
        t2 = d1 ^ a2;
        d2 = {t2[7:0], t2[31:8]};
        c2 = c1 + d2;
        t3 = b1 ^ c2;
        b2 = {t3[6:0], t3[31:7]};
    end

    assign a_o = a2;
    assign b_o = b2;
    assign c_o = c2;
    assign d_o = d2;
endmodule

// File: rtl/blk3_seq.sv
// Module: run sequencer, tracking the round and the mix group within it.
// Assumes LANES divides 4, so a group is all columns or all diagonals.
module blk3_seq
    import blk3_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SPR  = MIXES / LANES,
    localparam int SUBW = (SPR > 1) ? $clog2(SPR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic            load,
    output logic [SUBW-1:0] sub,
    output logic            round_end,
    output logic            fin
);
    logic [2:0] rnd;

    assign load      = start && !busy;
    assign round_end = busy && (int'(sub) == SPR - 1);
    assign fin       = round_end && (int'(rnd) == ROUNDS - 1);

    // Advance group and round counters; close the run after the last round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            sub  <= '0;
            rnd  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            done <= 1'b0;
            sub  <= '0;
            rnd  <= '0;
        end else if (busy) begin
            if (round_end) begin
                sub <= '0;
                if (fin) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rnd <= rnd + 3'd1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blk3_compress_core.sv
// Module: iterative BLAKE3 compression, LANES quarter-round mixes per cycle.
// Assumes LANES is 1, 2 or 4; data inputs are sampled only when start is accepted.
module blk3_compress_core
    import blk3_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SPR  = MIXES / LANES,
    localparam int SUBW = (SPR > 1) ? $clog2(SPR) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [255:0] cv_in,
    input  logic [511:0] msg_in,
    input  logic [63:0]  ctr_in,
    input  logic [31:0]  len_in,
    input  logic [31:0]  flags_in,
    output logic         busy,
    output logic         done,
    output logic [511:0] res_out
);
    word_t st  [WORDS];
    word_t nxt [WORDS];
    word_t msg [WORDS];
    logic            load, round_end, fin;
    logic [SUBW-1:0] sub;

    quad_t q   [LANES];
    word_t mo_a [LANES];
    word_t mo_b [LANES];
    word_t mo_c [LANES];
    word_t mo_d [LANES];

    blk3_seq #(.LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .load(load),
        .sub(sub), .round_end(round_end), .fin(fin)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [2:0] pos;
        assign pos = 3'(int'(sub) * LANES + k);
        assign q[k] = quad_of(pos);
        blk3_mix u_mix (
            .a_i(st[q[k].a]), .b_i(st[q[k].b]), .c_i(st[q[k].c]), .d_i(st[q[k].d]),
            .x_i(msg[{pos, 1'b0}]), .y_i(msg[{pos, 1'b1}]),
            .a_o(mo_a[k]), .b_o(mo_b[k]), .c_o(mo_c[k]), .d_o(mo_d[k])
        );
    end

    // Merge the lane outputs into the next state; lanes touch disjoint words.
    always_comb begin
        for (int i = 0; i < WORDS; i++) nxt[i] = st[i];
        for (int k = 0; k < LANES; k++) begin
            nxt[q[k].a] = mo_a[k];
            nxt[q[k].b] = mo_b[k];
            nxt[q[k].c] = mo_c[k];
            nxt[q[k].d] = mo_d[k];
        end
    end

    // Load the initial state and message, then update them each busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                st[i]  <= '0;
                msg[i] <= '0;
            end
        end else if (load) begin
            for (int i = 0; i < 8; i++) st[i] <= cv_in[32*i +: 32];
            for (int i = 0; i < 4; i++) st[8+i] <= IV[i];
            st[12] <= ctr_in[31:0];
            st[13] <= ctr_in[63:32];
            st[14] <= len_in;
            st[15] <= flags_in;
            for (int i = 0; i < WORDS; i++) msg[i] <= msg_in[32*i +: 32];
        end else if (busy) begin
            for (int i = 0; i < WORDS; i++) st[i] <= nxt[i];
            if (round_end)
                for (int i = 0; i < WORDS; i++) msg[i] <= msg[PERM[i]];
        end
    end

    // Capture the folded result at the end of the last round and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out <= '0;
        end else if (fin) begin
            for (int i = 0; i < 8; i++) begin
                res_out[32*i +: 32]     <= nxt[i] ^ nxt[i+8];
                res_out[32*(i+8) +: 32] <= nxt[i+8];
            end
        end
    end
endmodule

// File: rtl/blk3_check.sv
// Checker: handshake and timing properties of the compression engine.
// Assumes it is bound to blk3_compress_core with the same LANES value.
module blk3_check #(
    parameter int LANES = 4,
    localparam int STEPS = 56 / LANES
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [511:0] res_out
);
    logic [7:0] cnt;

    // Count busy cycles of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (start && !busy)   cnt <= '0;
        else if (busy)             cnt <= cnt + 8'd1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !done && res_out == '0));
    p_accept_r2:     assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && !done));
    p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n) (busy && cnt < 8'(STEPS - 1)) |=> busy);
    p_run_len_r4:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (cnt == 8'(STEPS) && done));
    p_hold_r5:       assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> (done && $stable(res_out)));
    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
endmodule

bind blk3_compress_core blk3_check #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .res_out(res_out)
);

// File: tb/tb_blk3_compress_core.sv
module tb_blk3_compress_core;
    localparam int LANES = 4;
    localparam int STEPS = 56 / LANES;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] cv_in = '0;
    logic [511:0] msg_in = '0;
    logic [63:0]  ctr_in = '0;
    logic [31:0]  len_in = '0;
    logic [31:0]  flags_in = '0;
    logic         busy, done;
    logic [511:0] res_out;

    int total = 0;
    int bad = 0;

    blk3_compress_core #(.LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cv_in(cv_in), .msg_in(msg_in),
        .ctr_in(ctr_in), .len_in(len_in), .flags_in(flags_in),
        .busy(busy), .done(done), .res_out(res_out)
    );

    always #10ns clk = ~clk;

    localparam logic [31:0] IVW [8] = '{32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A,
                                        32'h510E527F, 32'h9B05688C, 32'h1F83D9AB, 32'h5BE0CD19};
    localparam int P [16] = '{2, 6, 3, 10, 7, 0, 4, 13, 1, 11, 12, 5, 9, 14, 15, 8};

    task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ror(input logic [31:0] v, input int n);
        return (v >> n) | (v << (32 - n));
    endfunction

    // Reference mix on four words, returned as {a,b,c,d}.
    function automatic logic [127:0] gmix(input logic [31:0] a, b, c, d, x, y);
        a = a + b + x;  d = ror(d ^ a, 16);
        c = c + d;      b = ror(b ^ c, 12);
        a = a + b + y;  d = ror(d ^ a, 8);
        c = c + d;      b = ror(b ^ c, 7);
        return {a, b, c, d};
    endfunction

    function automatic logic [511:0] model(input logic [255:0] cv, input logic [511:0] m,
                                           input logic [63:0] ctr, input logic [31:0] len,
                                           input logic [31:0] fl);
        logic [31:0] v [16];
        int s [16];
        int t [16];
        int ia, ib, ic, id;
        logic [127:0] r4;
        logic [511:0] o;
        for (int i = 0; i < 8; i++) v[i] = cv[32*i +: 32];
        for (int i = 0; i < 4; i++) v[8+i] = IVW[i];
        v[12] = ctr[31:0]; v[13] = ctr[63:32]; v[14] = len; v[15] = fl;
        for (int i = 0; i < 16; i++) s[i] = i;
        for (int r = 0; r < 7; r++) begin
            for (int k = 0; k < 8; k++) begin
                if (k < 4) begin
                    ia = k; ib = k + 4; ic = k + 8; id = k + 12;
                end else begin
                    ia = k - 4; ib = 4 + (k - 3) % 4; ic = 8 + (k - 2) % 4; id = 12 + (k - 1) % 4;
                end
                r4 = gmix(v[ia], v[ib], v[ic], v[id], m[32*s[2*k] +: 32], m[32*s[2*k+1] +: 32]);
                {v[ia], v[ib], v[ic], v[id]} = r4;
            end
            for (int i = 0; i < 16; i++) t[i] = s[P[i]];
            for (int i = 0; i < 16; i++) s[i] = t[i];
        end
        for (int i = 0; i < 8; i++) begin
            o[32*i +: 32]     = v[i] ^ v[i+8];
            o[32*(i+8) +: 32] = v[i+8];
        end
        return o;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] x;
        for (int i = 0; i < 8; i++) x[32*i +: 32] = $urandom;
        return x;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] x;
        for (int i = 0; i < 16; i++) x[32*i +: 32] = $urandom;
        return x;
    endfunction

    // Start one run; optionally inject a stray start mid-run; check timing and result.
    task automatic run(input logic [255:0] cv, input logic [511:0] m, input logic [63:0] ctr,
                       input logic [31:0] len, input logic [31:0] fl, input bit stray);
        logic [511:0] exp;
        int n;
        exp = model(cv, m, ctr, len, fl);
        @(negedge clk);
        cv_in = cv; msg_in = m; ctr_in = ctr; len_in = len; flags_in = fl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R2 accept", {510'd0, busy, done}, {510'd0, 2'b10});
        n = 0;
        while (!done && n < 1000) begin
            if (stray && n == 3) begin
                cv_in = rnd256(); msg_in = rnd512(); ctr_in = {$urandom, $urandom};
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == STEPS, stray ? "R3 R4 run length with stray start" : "R4 run length",
              512'(n), 512'(STEPS));
        check(!busy, "R12 busy low at done", {511'd0, busy}, '0);
        check(res_out == exp, stray ? "R3 result unaffected" : "R6 R7 R8 R9 R10 result",
              res_out, exp);
    endtask

    initial begin
        #(20ns * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [511:0] held;
        logic [255:0] dig;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && res_out == '0, "R1 reset state",
              res_out ^ {510'd0, busy, done}, '0);

        // R11: digest of the empty input.
        begin
            logic [255:0] ivcv;
            for (int i = 0; i < 8; i++) ivcv[32*i +: 32] = IVW[i];
            run(ivcv, '0, 64'd0, 32'd0, 32'd11, 1'b0);
            dig = {32'h62321fe4, 32'hca939acc, 32'hb712c1ad, 32'hc925cb9b,
                   32'h49c9dc36, 32'hea4d40a0, 32'ha6a1f9f5, 32'hb94913af};
            check(res_out[255:0] == dig, "R11 empty digest", {256'd0, res_out[255:0]}, {256'd0, dig});
        end

        // R5: the result holds while the data inputs churn.
        held = res_out;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cv_in = rnd256(); msg_in = rnd512(); len_in = $urandom; flags_in = $urandom;
        end
        @(negedge clk);
        check(done && res_out == held, "R5 hold", res_out, held);

        // Directed corners: all ones, counter with only the upper half set.
        run('1, '1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run('0, '0, 64'h0000_0001_0000_0000, 32'd64, 32'd0, 1'b0);
        // R3: stray start during a run.
        run(rnd256(), rnd512(), {$urandom, $urandom}, 32'd64, 32'd3, 1'b1);
        // Random runs; back-to-back starts after done also cover R2.
        for (int k = 0; k < 16; k++)
            run(rnd256(), rnd512(), {$urandom, $urandom}, $urandom % 65, $urandom % 32, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule